// File: doc/BRIEF.md
# Dual-Order Serial Converter Output Engine

This block is the digital side of a serial successive-approximation converter that has only three wires to its host: an active-low select, a shift clock and one data line. There is no data input and no command word. When select goes low the block waits for the first shift-clock pulse. That pulse enables the data driver and sends one zero bit. The next pulses send the conversion word from its top bit down to bit 0. The pulses after that replay the word from bit 1 back up to its top bit. Bit 0 is sent only once, at the turnaround. The word is plain unsigned binary, because the converter has a single differential input and works in unipolar mode.

All logic runs on a system clock. Select and the shift clock are resynchronised into that domain, and every output bit is launched on a detected falling edge of the shift clock. Falling edges that arrive before a set number of system-clock cycles have passed since select fell are ignored. This models the wake-up time of the converter. Raising select at any point aborts the transfer, releases the data driver and puts the block back into low-power idle, which `idle_lp` reports.

A parameter chooses how the word is produced. In the latched variant the word is taken from `result_in` when select falls. In the successive-approximation variant, each top-down bit is decided by an external comparator at the moment it is shifted out. The word decided that way is then used for the replay.

Top module: `dual_order_ser_adc`

## Requirements
- R1: After reset `dout_oe` is 0, `dout_val` is 0 and `idle_lp` is 1.
- R2: `idle_lp` goes to 0 within 4 system clocks after `cs_n` falls, and back to 1 within 4 system clocks after `cs_n` rises.
- R3: A falling `cs_n` alone does not enable the driver: `dout_oe` stays 0 until the first qualified falling edge of `sclk`.
- R4: Falling edges of `sclk` that are detected fewer than SETUP_CYCLES system clocks after the synchronised `cs_n` went low are ignored: `dout_oe` stays 0, and the next qualified falling edge still sends the zero bit.
- R5: The first qualified falling edge of `sclk` sets `dout_oe` to 1 and drives `dout_val` to 0.
- R6: The next DATA_W falling edges drive the word bits DATA_W-1 down to 0, in that order.
- R7: The next DATA_W-1 falling edges drive the word bits 1 up to DATA_W-1, in that order.
- R8: The falling edge after the last replayed bit sets `dout_oe` to 0, and further falling edges while `cs_n` stays low keep it at 0.
- R9: Raising `cs_n` during a transfer clears `dout_oe` within 4 system clocks. The next transfer restarts with the zero bit and a freshly obtained word.
- R10: In the latched variant (USE_SAR = 0), `result_in` is captured when `cs_n` falls. Later changes to `result_in` do not alter the bits sent in that transfer.
- R11: In the successive-approximation variant (USE_SAR = 1), just before top-down step k, `trial_word` holds the already decided upper bits, a 1 at bit k and 0 below bit k. The bit sent at step k is `cmp_in`, where 1 means the input is at or above the trial level. The replay uses the decided word.
- R12: `dout_val` and `dout_oe` do not change on a rising edge of `sclk`. They change only on a falling edge or when `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high also means power down |
| sclk | input | 1 | Shift clock from the host, idle low |
| result_in | input | DATA_W | Conversion word for the latched variant |
| cmp_in | input | 1 | Comparator decision for the successive-approximation variant |
| trial_word | output | DATA_W | Current trial level for the comparator (zero in the latched variant) |
| dout_val | output | 1 | Value on the serial data line |
| dout_oe | output | 1 | Data line driver enable; 0 means high impedance |
| idle_lp | output | 1 | 1 while the block is in low-power idle |

## Verification
The bench builds two copies with DATA_W = 6, SYNC_STAGES = 2 and SETUP_CYCLES = 8. One copy is latched and one uses successive approximation, and both share the same select and shift clock. The narrow word allows all 64 codes to be swept in each variant: the latched copy sends each code from `result_in`, and the approximation copy converts the same code through a modelled comparator. The short setup count puts an early clock edge inside the wake-up window in every eighth transfer. Further tests cover aborts partway through a transfer, a change of `result_in` in the middle of a transfer, and the extra clocks after the last bit.

// File: rtl/dso_pkg.sv
package dso_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_WAIT = 3'd1,
      PH_DOWN = 3'd2,
      PH_UP   = 3'd3,
      PH_DONE = 3'd4
   } dso_phase_e;
endpackage

// File: rtl/dso_sync_edge.sv
module dso_sync_edge #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dso_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
         prev_q  <= RESET_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = ~prev_q &  chain_q[STAGES-1];
   assign fall_o  =  prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dso_setup_timer.sv
module dso_setup_timer #(
   parameter int SETUP_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_low_i,
   output logic ready_o
);
   if (SETUP_CYCLES < 1) begin : g_bad_setup
      $error("dso_setup_timer: SETUP_CYCLES must be at least 1");
   end

   localparam int CNT_W = $clog2(SETUP_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETUP_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!sel_low_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LIMIT) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign ready_o = (cnt_q == LIMIT);

   AST_READY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> $past(sel_low_i)); // R4
endmodule

// File: rtl/dso_word_src.sv
module dso_word_src #(
   parameter int DATA_W  = 12,
   parameter bit USE_SAR = 1'b0,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              start_i,
   input  logic              step_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic              cmp_i,
   output logic [DATA_W-1:0] word_o,
   output logic              down_bit_o,
   output logic [DATA_W-1:0] trial_o
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] word_q;

   if (USE_SAR) begin : g_sar
      logic [DATA_W-1:0] word_nxt;
      logic              unused_sar;
      assign unused_sar = ^{capture_i, result_i};

      always_comb begin
         word_nxt        = word_q;
         word_nxt[idx_i] = cmp_i;
         if (idx_i != '0) begin
            word_nxt[idx_i - IDX_W'(1)] = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (start_i) begin
            word_q          <= '0;
            word_q[TOP_IDX] <= 1'b1;
         end else if (step_i) begin
            word_q <= word_nxt;
         end
      end

      assign down_bit_o = cmp_i;
      assign trial_o    = word_q;

      AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
         step_i |-> word_q[idx_i]); // R11
   end else begin : g_latch
      logic unused_latch;
      assign unused_latch = ^{start_i, step_i, cmp_i};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (capture_i) begin
            word_q <= result_i;
         end
      end

      assign down_bit_o = word_q[idx_i];
      assign trial_o    = '0;

      AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         !capture_i |=> $stable(word_q)); // R10
   end

   assign word_o = word_q;
endmodule

// File: rtl/dso_sequencer.sv
module dso_sequencer
   import dso_pkg::*;
#(
   parameter int DATA_W = 12,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_high_i,
   input  logic              sclk_fall_i,
   input  logic              sclk_rise_i,
   input  logic              ready_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              down_bit_i,
   output logic              start_o,
   output logic              step_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              dout_o,
   output logic              oe_o,
   output logic              idle_o
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   dso_phase_e       phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             dout_q;
   logic             oe_q;

   assign start_o = sclk_fall_i && ready_i && (phase_q == PH_WAIT) && !sel_high_i;
   assign step_o  = sclk_fall_i && (phase_q == PH_DOWN) && !sel_high_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= TOP_IDX;
         dout_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (sel_high_i) begin
         phase_q <= PH_IDLE;
         idx_q   <= TOP_IDX;
         dout_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: phase_q <= PH_WAIT;
            PH_WAIT: begin
               if (start_o) begin
                  oe_q    <= 1'b1;
                  dout_q  <= 1'b0;
                  idx_q   <= TOP_IDX;
                  phase_q <= PH_DOWN;
               end
            end
            PH_DOWN: begin
               if (sclk_fall_i) begin
                  dout_q <= down_bit_i;
                  if (idx_q == '0) begin
                     idx_q   <= IDX_W'(1);
                     phase_q <= PH_UP;
                  end else begin
                     idx_q <= idx_q - IDX_W'(1);
                  end
               end
            end
            PH_UP: begin
               if (sclk_fall_i) begin
                  dout_q <= word_i[idx_q];
                  if (idx_q == TOP_IDX) begin
                     phase_q <= PH_DONE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            PH_DONE: begin
               if (sclk_fall_i) begin
                  oe_q   <= 1'b0;
                  dout_q <= 1'b0;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign idx_o  = idx_q;
   assign dout_o = dout_q;
   assign oe_o   = oe_q;
   assign idle_o = (phase_q == PH_IDLE);

   AST_OE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(sclk_fall_i)); // R3
   AST_NULL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> (dout_q == 1'b0)); // R5
   AST_EARLY_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall_i && !ready_i && !oe_q) |=> !oe_q); // R4
   AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_high_i |=> (!oe_q && idle_o)); // R9
   AST_RISE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise_i && !sel_high_i) |=> ($stable(dout_q) && $stable(oe_q))); // R12
   AST_SINGLE_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_UP) |-> (idx_q != '0)); // R7
endmodule

// File: rtl/dual_order_ser_adc.sv
module dual_order_ser_adc #(
   parameter int DATA_W       = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int SETUP_CYCLES = 16,
   parameter bit USE_SAR      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] result_in,
   input  logic              cmp_in,
   output logic [DATA_W-1:0] trial_word,
   output logic              dout_val,
   output logic              dout_oe,
   output logic              idle_lp
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dual_order_ser_adc: DATA_W must be at least 2");
   end

   localparam int IDX_W = $clog2(DATA_W);

   logic              sel_high, sel_rise, sel_fall;
   logic              sclk_lvl, sclk_rise, sclk_fall;
   logic              ready;
   logic              start, step, down_bit;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] word;
   logic              unused_top;

   assign unused_top = ^{sel_rise, sclk_lvl};

   dso_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_in(cs_n),
      .level_o(sel_high), .rise_o(sel_rise), .fall_o(sel_fall));

   dso_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d_in(sclk),
      .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));

   dso_setup_timer #(.SETUP_CYCLES(SETUP_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .sel_low_i(~sel_high), .ready_o(ready));

   dso_word_src #(.DATA_W(DATA_W), .USE_SAR(USE_SAR)) u_word (
      .clk(clk), .rst_n(rst_n), .capture_i(sel_fall), .start_i(start),
      .step_i(step), .idx_i(idx), .result_i(result_in), .cmp_i(cmp_in),
      .word_o(word), .down_bit_o(down_bit), .trial_o(trial_word));

   dso_sequencer #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .sel_high_i(sel_high),
      .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise), .ready_i(ready),
      .word_i(word), .down_bit_i(down_bit), .start_o(start), .step_o(step),
      .idx_o(idx), .dout_o(dout_val), .oe_o(dout_oe), .idle_o(idle_lp));
endmodule

// File: tb/sim_dual_order_ser_adc.sv
`timescale 1ns/1ps
module sim_dual_order_ser_adc;
   localparam int W     = 6;
   localparam int SETUP = 8;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic [W-1:0] res0 = '0;
   logic [W-1:0] analog = '0;
   logic [W-1:0] trial0, trial1;
   logic dv0, oe0, idle0, dv1, oe1, idle1;
   logic cmp1;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign cmp1 = (analog >= trial1);

   dual_order_ser_adc #(.DATA_W(W), .SYNC_STAGES(2), .SETUP_CYCLES(SETUP), .USE_SAR(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .result_in(res0),
      .cmp_in(1'b0), .trial_word(trial0), .dout_val(dv0), .dout_oe(oe0), .idle_lp(idle0));

   dual_order_ser_adc #(.DATA_W(W), .SYNC_STAGES(2), .SETUP_CYCLES(SETUP), .USE_SAR(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .result_in('0),
      .cmp_in(cmp1), .trial_word(trial1), .dout_val(dv1), .dout_oe(oe1), .idle_lp(idle1));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // one shift-clock pulse; checks that the rising half changes nothing (R12)
   task automatic pulse();
      logic p0, p1, q0, q1;
      p0 = dv0; p1 = dv1; q0 = oe0; q1 = oe1;
      sclk = 1'b1;
      wait_clk(HALF);
      chk("R12 rise u0", {dv0, oe0}, {p0, q0});
      chk("R12 rise u1", {dv1, oe1}, {p1, q1});
      sclk = 1'b0;
      wait_clk(HALF);
   endtask

   function automatic int exp_bit(input int v, input int n);
      if (n <= W) return (v >> (W - n)) & 1;
      return (v >> (n - W)) & 1;
   endfunction

   // full transfer of code v; early: an edge inside the setup window;
   // stop_at: number of pulses before aborting (0 means full transfer)
   task automatic xfer(input int v, input bit early, input int stop_at, input bit flip);
      res0   = W'(v);
      analog = W'(v);
      wait_clk(2);
      cs_n = 1'b0;
      if (early) begin
         @(posedge clk); sclk = 1'b1;
         @(posedge clk); sclk = 1'b0;
         wait_clk(3);
         chk("R4 early edge u0 oe", oe0, 0);
         chk("R4 early edge u1 oe", oe1, 0);
      end
      wait_clk(SETUP + 4);
      chk("R3 select alone u0 oe", oe0, 0);
      chk("R3 select alone u1 oe", oe1, 0);
      chk("R2 awake u0", idle0, 0);
      chk("R2 awake u1", idle1, 0);
      pulse();
      chk("R5 null oe u0", oe0, 1);
      chk("R5 null oe u1", oe1, 1);
      chk("R5 null val u0", dv0, 0);
      chk("R5 null val u1", dv1, 0);
      for (int n = 1; n <= 2*W - 1; n++) begin
         if (stop_at != 0 && n > stop_at) break;
         if (n <= W) begin
            int k;
            k = W - n;
            chk("R11 trial", int'(trial1), (v & ~((1 << (k + 1)) - 1)) | (1 << k));
         end
         if (flip && n == 2) res0 = ~W'(v);
         pulse();
         if (n <= W) begin
            chk("R6 down u0", dv0, exp_bit(v, n));
            chk("R6 down u1 R11", dv1, exp_bit(v, n));
         end else begin
            chk("R7 up u0", dv0, exp_bit(v, n));
            chk("R7 up u1 R11", dv1, exp_bit(v, n));
         end
         if (flip) chk("R10 captured", dv0, exp_bit(v, n));
      end
      if (stop_at == 0) begin
         for (int e = 0; e < 2; e++) begin
            pulse();
            chk("R8 released u0", oe0, 0);
            chk("R8 released u1", oe1, 0);
         end
      end
      cs_n = 1'b1;
      wait_clk(4);
      if (stop_at != 0) begin
         chk("R9 abort u0", oe0, 0);
         chk("R9 abort u1", oe1, 0);
      end
      chk("R2 idle u0", idle0, 1);
      chk("R2 idle u1", idle1, 1);
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      chk("R1 reset oe", {oe0, oe1}, 0);
      chk("R1 reset val", {dv0, dv1}, 0);
      chk("R1 reset idle", {idle0, idle1}, 3);
      for (int v = 0; v < (1 << W); v++) begin
         xfer(v, (v % 8) == 0, 0, (v % 5) == 1);
      end
      xfer(6'h2D, 1'b0, 3, 1'b0);   // R9 abort during top-down phase
      xfer(6'h13, 1'b0, 0, 1'b0);
      xfer(6'h3E, 1'b0, 8, 1'b0);   // R9 abort during replay
      xfer(6'h21, 1'b1, 0, 1'b0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule